// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous requester and an external 64K x 16 asynchronous static RAM. The RAM has one bidirectional data bus that both sides share. The requester presents one word access at a time with a request/ready handshake. Each access carries an address, a write flag, write data and a per-byte enable mask. The controller then plays out the chip select, write enable, output enable and per-byte enable waveforms. All of these are active low and come straight from flip-flops. Read results come back with a one-cycle valid strobe.

The length of each phase is given in nanoseconds through parameters and converted to whole clock cycles at elaboration, always rounding up. Output enable stays high for the whole of every write, so the shorter write-pulse limit applies. The controller drives the data pins only while a write is active, plus one hold cycle after write enable rises. When a write follows a read, the controller inserts an idle turnaround cycle so that the memory and the controller never drive the data pins at the same time.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever no access is in progress, `ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is all ones, and `mem_dq_oe` is 0.
- R2: A read accepted at a clock edge (`req`=1, `we`=0, `ready`=1) holds `mem_cs_n`=0 and `mem_oe_n`=0, with `mem_we_n`=1 and `mem_dq_oe`=0, for exactly RD_CYC cycles starting in the next cycle. RD_CYC is 3 with the default parameters.
- R3: `rd_valid` is 1 for exactly one cycle, the cycle after the last read cycle. In that cycle `rd_data` holds the bus value sampled at the end of the last read cycle, with disabled byte lanes forced to zero.
- R4: A write holds `mem_we_n`=0 with `mem_cs_n`=0 for WR_CYC cycles (2 with the default parameters). It then holds one more cycle with `mem_we_n`=1 and `mem_cs_n`=0. `mem_dq_oe` is 1 and `mem_dq_out` equals the write data in all of these cycles, and `mem_oe_n` stays 1 throughout.
- R5: Bit 0 of `byte_en` enables data bits 7..0 and bit 1 enables bits 15..8, with 1 meaning enabled. During an access, `mem_be_n` is the inverse of `byte_en`, and a lane that is not enabled is neither written nor returned.
- R6: A write accepted when the previous access was a read starts with one turnaround cycle in which all memory controls are high and `mem_dq_oe` is 0. `mem_we_n` falls in the cycle after that.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: A request presented while `ready` is 0 is ignored. It changes neither the current access nor the sequence of accesses that follows.
- R9: `mem_addr`, `mem_be_n` and `mem_dq_out` stay constant for the whole of an access.
- R10: RD_CYC is the larger of ceil(T_ACC_NS/CLK_NS) and ceil(T_CYC_NS/CLK_NS). WR_CYC is the largest of ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS), ceil(T_CYC_NS/CLK_NS)-1 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, taken when ready is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data |
| byte_en | input | 2 | Per-lane enable, bit 0 = bits 7..0 |
| ready | output | 1 | Controller idle and able to take a request |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Memory byte enables, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data received from the memory pins |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
The stability and pulse assertions rely on a requester that holds `req` low or changes it only between clock edges. They also rely on a memory that drives `mem_dq_in` only while chip select and output enable are low and write enable is high. The bench's memory model follows exactly that rule: it returns zero on disabled lanes and on every cycle in which it is not selected for reading. The stimulus drives `req` high with changing address, data and mask during busy cycles, to exercise the ignore rule. It always lowers `req` in the cycle in which `ready` returns, unless it is deliberately starting the next access.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_RD,
        ST_WR,
        ST_WREC
    } sram_st_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R10: each phase counts down one per cycle until it expires
    a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic [LANES-1:0]  be_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_masked
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_masked[g*LANE_W +: LANE_W] =
            be_n[g] ? '0 : dq_in[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 4,
    parameter int T_CYC_NS  = 10,
    parameter int T_ACC_NS  = 10,
    parameter int T_WP_NS   = 7,
    parameter int T_DS_NS   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   byte_en,
    output logic                  ready,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  mem_cs_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_dq_out,
    input  logic [DATA_W-1:0]     mem_dq_in,
    output logic                  mem_dq_oe
);
    localparam int LANES   = DATA_W / 8;
    localparam int CYC_CLK = cdiv(T_CYC_NS, CLK_NS);
    localparam int RD_CYC  = imax(cdiv(T_ACC_NS, CLK_NS), CYC_CLK);
    localparam int WR_CYC  = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DS_NS, CLK_NS)),
                                  imax(CYC_CLK - 1, 1));
    localparam int CNT_W   = $clog2(imax(RD_CYC, WR_CYC) + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

    typedef struct packed {
        sram_st_e            st;
        logic                last_rd;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    ben;
        logic                cs_n;
        logic                we_n;
        logic                oe_n;
        logic [LANES-1:0]    be_n;
        logic                dq_oe;
        logic                rd_valid;
        logic [DATA_W-1:0]   rd_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             t_load_d;
    logic [CNT_W-1:0] t_val_d;
    logic             t_done;
    logic [DATA_W-1:0] rd_masked;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load_d),
        .load_val (t_val_d),
        .done     (t_done)
    );

    sram_ctl_lanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .be_n      (ctl_q.be_n),
        .dq_in     (mem_dq_in),
        .dq_masked (rd_masked)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        t_load_d       = 1'b0;
        t_val_d        = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.addr  = addr;
                    ctl_d.wdata = wdata;
                    ctl_d.ben   = byte_en;
                    if (we) begin
                        ctl_d.last_rd = 1'b0;
                        if (ctl_q.last_rd) begin
                            ctl_d.st = ST_TURN;
                        end else begin
                            ctl_d.st = ST_WR;
                            t_load_d = 1'b1;
                            t_val_d  = WR_LOAD;
                        end
                    end else begin
                        ctl_d.last_rd = 1'b1;
                        ctl_d.st      = ST_RD;
                        t_load_d      = 1'b1;
                        t_val_d       = RD_LOAD;
                    end
                end
            end
            ST_TURN: begin
                ctl_d.st = ST_WR;
                t_load_d = 1'b1;
                t_val_d  = WR_LOAD;
            end
            ST_WR: begin
                if (t_done) ctl_d.st = ST_WREC;
            end
            ST_WREC: begin
                ctl_d.st = ST_IDLE;
            end
            ST_RD: begin
                if (t_done) begin
                    ctl_d.st       = ST_IDLE;
                    ctl_d.rd_valid = 1'b1;
                    ctl_d.rd_data  = rd_masked;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        ctl_d.cs_n  = !(ctl_d.st inside {ST_RD, ST_WR, ST_WREC});
        ctl_d.we_n  = (ctl_d.st != ST_WR);
        ctl_d.oe_n  = (ctl_d.st != ST_RD);
        ctl_d.be_n  = ctl_d.cs_n ? '1 : ~ctl_d.ben;
        ctl_d.dq_oe = (ctl_d.st inside {ST_WR, ST_WREC});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_IDLE;
            ctl_q.cs_n     <= 1'b1;
            ctl_q.we_n     <= 1'b1;
            ctl_q.oe_n     <= 1'b1;
            ctl_q.be_n     <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready      = (ctl_q.st == ST_IDLE);
    assign rd_valid   = ctl_q.rd_valid;
    assign rd_data    = ctl_q.rd_data;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_be_n   = ctl_q.be_n;
    assign mem_addr   = ctl_q.addr;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;

    // R1: an idle controller leaves the memory deselected
    a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && !mem_dq_oe));

    // R3: read strobe never lasts two cycles
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R4: output enable stays high and data is driven during the write pulse
    a_r4_write_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_dq_oe));

    // R4: data and select held one cycle after write enable rises
    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n));

    // R5: byte enables inactive while deselected
    a_r5_be_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_be_n == '1));

    // R6: write pulse never starts straight after an output-enabled cycle
    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_dq_oe)));

    // R7: controller drivers and memory outputs never enabled together
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R9: address, lanes and data stable across an access
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |=> (mem_cs_n || ($stable(mem_addr) && $stable(mem_be_n)
                                    && $stable(mem_dq_out))));

endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;

    localparam int RD_N = 3;   // R10: max(ceil(10/4), ceil(10/4))
    localparam int WR_N = 2;   // R10: max(ceil(7/4), ceil(5/4), ceil(10/4)-1)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  byte_en = '0;
    logic        ready, rd_valid;
    logic [15:0] rd_data;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_addr, mem_dq_out;
    logic [15:0] mem_dq_in;

    sram_ctl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .byte_en(byte_en), .ready(ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // ---------------- memory pin model ----------------
    logic [15:0] sram_mem [int];
    logic [15:0] ref_mem  [int];

    function automatic logic [15:0] init_val(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] sram_rd(input logic [15:0] a);
        return sram_mem.exists(a) ? sram_mem[a] : init_val(a);
    endfunction

    always_comb begin
        mem_dq_in = 16'h0000;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            if (!mem_be_n[0]) mem_dq_in[7:0]  = sram_rd(mem_addr)[7:0];
            if (!mem_be_n[1]) mem_dq_in[15:8] = sram_rd(mem_addr)[15:8];
        end
    end

    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n) begin
            logic [15:0] v;
            v = sram_rd(mem_addr);
            if (!mem_be_n[0]) v[7:0]  = mem_dq_out[7:0];
            if (!mem_be_n[1]) v[15:8] = mem_dq_out[15:8];
            sram_mem[mem_addr] = v;
        end
        if (rst_n)  // R7: memory driving while controller drives
            chk("R7 contention", {31'd0, mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n}, 32'd0);
    end

    // ---------------- cycle reference model ----------------
    typedef struct {
        logic        cs_n, we_n, oe_n, drv, rdy, rv;
        logic [1:0]  be_n;
        logic [15:0] a, wd, rdata;
        string       tag;
    } frame_t;

    frame_t fq[$];
    frame_t cur;
    logic   last_was_rd = 1'b0;

    function automatic frame_t idle_frame();
        frame_t f;
        f.cs_n = 1; f.we_n = 1; f.oe_n = 1; f.drv = 0; f.rdy = 1; f.rv = 0;
        f.be_n = 2'b11; f.a = '0; f.wd = '0; f.rdata = '0; f.tag = "R1";
        return f;
    endfunction

    initial cur = idle_frame();

    always @(posedge clk) begin
        if (rst_n) cur <= (fq.size() != 0) ? fq.pop_front() : idle_frame();
    end

    always @(negedge clk) begin
        chk({cur.tag, " cs_n"}, {31'd0, mem_cs_n}, {31'd0, cur.cs_n});
        chk({cur.tag, " we_n"}, {31'd0, mem_we_n}, {31'd0, cur.we_n});
        chk({cur.tag, " oe_n"}, {31'd0, mem_oe_n}, {31'd0, cur.oe_n});
        chk({cur.tag, " dq_oe"}, {31'd0, mem_dq_oe}, {31'd0, cur.drv});
        chk("R5 be_n", {30'd0, mem_be_n}, {30'd0, cur.be_n});
        chk("R8 ready", {31'd0, ready}, {31'd0, cur.rdy});
        chk("R3 rd_valid", {31'd0, rd_valid}, {31'd0, cur.rv});
        if (cur.rv) chk("R3 rd_data", {16'd0, rd_data}, {16'd0, cur.rdata});
        if (!cur.cs_n) chk("R9 mem_addr", {16'd0, mem_addr}, {16'd0, cur.a});
        if (cur.drv) chk("R4 dq_out", {16'd0, mem_dq_out}, {16'd0, cur.wd});
    end

    // ---------------- stimulus ----------------
    task automatic do_op(input logic w, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be, input logic spam);
        frame_t f;
        logic [15:0] e;
        while (!ready) @(negedge clk);
        req = 1; we = w; addr = a; wdata = d; byte_en = be;
        if (w) begin
            if (last_was_rd) begin           // R6 turnaround cycle
                f = idle_frame(); f.rdy = 0; f.tag = "R6";
                fq.push_back(f);
            end
            for (int i = 0; i < WR_N; i++) begin
                f = idle_frame(); f.rdy = 0; f.cs_n = 0; f.we_n = 0; f.drv = 1;
                f.be_n = ~be; f.a = a; f.wd = d; f.tag = "R4";
                fq.push_back(f);
            end
            f = idle_frame(); f.rdy = 0; f.cs_n = 0; f.drv = 1;
            f.be_n = ~be; f.a = a; f.wd = d; f.tag = "R4";
            fq.push_back(f);
            e = ref_mem.exists(a) ? ref_mem[a] : init_val(a);
            if (be[0]) e[7:0]  = d[7:0];
            if (be[1]) e[15:8] = d[15:8];
            ref_mem[a] = e;
            last_was_rd = 0;
        end else begin
            for (int i = 0; i < RD_N; i++) begin
                f = idle_frame(); f.rdy = 0; f.cs_n = 0; f.oe_n = 0;
                f.be_n = ~be; f.a = a; f.tag = "R2";
                fq.push_back(f);
            end
            e = ref_mem.exists(a) ? ref_mem[a] : init_val(a);
            if (!be[0]) e[7:0]  = 8'h00;
            if (!be[1]) e[15:8] = 8'h00;
            f = idle_frame(); f.rv = 1; f.rdata = e; f.tag = "R3";
            fq.push_back(f);
            last_was_rd = 1;
        end
        forever begin
            @(negedge clk);
            if (cur.rdy) begin
                req = 0;
                break;
            end
            if (spam) begin   // R8: requests while busy are ignored
                req = 1; we = ~we; addr = ~addr + 16'd7;
                wdata = wdata ^ 16'hFFFF; byte_en = ~byte_en;
            end else begin
                req = 0;
            end
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready in reset", {31'd0, ready}, 32'd1);
        chk("R1 cs_n in reset", {31'd0, mem_cs_n}, 32'd1);
        rst_n = 1;
        @(negedge clk);
        do_op(1, 16'h0010, 16'h1234, 2'b11, 0);   // R4 full write
        do_op(0, 16'h0010, 16'h0000, 2'b11, 0);   // R2 R3 read back
        do_op(1, 16'h0010, 16'hABCD, 2'b01, 0);   // R5 R6 lower lane after read
        do_op(0, 16'h0010, 16'h0000, 2'b10, 0);   // R5 upper only
        do_op(0, 16'h0010, 16'h0000, 2'b01, 0);   // R5 lower only
        do_op(1, 16'hFFFF, 16'h5A5A, 2'b11, 0);   // top address
        do_op(1, 16'h0000, 16'h0F0F, 2'b10, 0);   // back-to-back writes
        do_op(0, 16'hFFFF, 16'h0000, 2'b11, 1);   // R8 busy spam during read
        do_op(0, 16'h0000, 16'h0000, 2'b11, 0);
        do_op(1, 16'h0010, 16'h0000, 2'b00, 1);   // R5 no lanes, R8 spam in write
        do_op(0, 16'h0010, 16'h0000, 2'b11, 0);   // unchanged 12CD
        do_op(0, 16'h0123, 16'h0000, 2'b11, 0);   // untouched word
        for (int i = 0; i < 60; i++) begin
            logic [15:0] ra;
            ra = 16'h0100 + 16'($urandom_range(0, 7));
            do_op(1'($urandom_range(0, 1)), ra, 16'($urandom),
                  2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        end
        repeat (RD_N + WR_N + 4) @(negedge clk);
        chk("R1 idle at end", {31'd0, ready}, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule